// File: doc/BRIEF.md
# Word-Programmed Nonvolatile Array Controller

This block sits on a simple on-chip bus and fronts a small nonvolatile array, modelled here as a plain RAM. The bus sees two windows, chosen by one select input: a register window for control and status, and a data window that maps the array as 32-bit words on a 4-byte stride. With word mode enabled, a single store into the data window writes the word and starts a timed erase/program cycle. When the cycle finishes, a sticky completion flag is raised, and software clears it by writing one to a separate clear register.

Program and wake timing are both counted in ticks of one programmable divider. The divider register holds the division factor minus one. Software picks the value so that the divided rate falls between 800 kHz and 1600 kHz, ideally near 1.5 MHz. At that rate, the default program length of 4500 ticks is about 3 ms and the default wake interval of 150 ticks is about 100 us. A power-down bit puts the array to sleep. After it is cleared, the array becomes usable only once the wake interval has passed. The top page of the array holds start-up data and never accepts stores.

Top module: `nvm_word_prog`

## Requirements
- R1: After reset, the divider register reads 0, word mode reads 0, power-down reads 1, the status register reads 0 and `bus_rdata` is 0.
- R2: Register window (`bus_win`=0): word mode is bit 0 at offset 0x00C, the divider is bits [7:0] at 0x014, power-down is bit 0 at 0x018, and the completion flag is bit 2 of the status register at 0xFE0. Every other offset reads 0, including the clear register at 0xFE8. A read request loads `bus_rdata` at the next clock edge, and `bus_rdata` holds that value until the next read request.
- R3: A data-window write (`bus_win`=1) is accepted when word mode is 1, power-down is 0, the wake interval is over, no cycle is running and the address is outside the top page. An accepted write stores `bus_wdata` at word index `bus_addr[8:2]`. Address bits [1:0] are ignored, both for writes and for reads.
- R4: The divider produces one tick every (divider value + 1) clocks. Writing the divider register restarts the tick count from zero.
- R5: An accepted write starts a program cycle. The cycle ends after PROG_TICKS ticks, counted from the clock after the write, and the completion flag is set at that same edge.
- R6: The completion flag stays set until a register write to 0xFE8 with bit 2 = 1. A clear write with bit 2 = 0 has no effect. If the flag is being set and cleared at the same edge, setting wins.
- R7: A data write that arrives while a cycle is running is dropped. It neither changes the stored word nor restarts the cycle timer.
- R8: A data write whose word index falls in the top PAGE_BYTES of the array is dropped, and no cycle starts.
- R9: While power-down is 1, data writes are dropped and data reads return 0. After power-down is written to 0, data reads return 0 and data writes are dropped until WAKE_TICKS ticks have passed.
- R10: With word mode 0, data writes are dropped and no cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = register window, 1 = data window |
| bus_addr | input | 12 | Byte address within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The hardest case to reach from the ports is a write that collides with a cycle already in flight, where a restarted timer would look almost the same as a correct one. To expose it, the bench sets the divider to zero, so that every clock is a tick, and issues the second write exactly two clocks into the cycle. It then reads the status register on the two consecutive clocks where the original cycle must end. The same exact timing is used to land a clear write on the very edge where the flag is set, and to read the data window in the window between releasing power-down and the end of the wake interval. A behavioural model runs alongside and compares `bus_rdata` on every clock.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;
  localparam logic [BUS_AW-1:0] OFS_MODE  = 12'h00C;
  localparam logic [BUS_AW-1:0] OFS_DIV   = 12'h014;
  localparam logic [BUS_AW-1:0] OFS_SLEEP = 12'h018;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 12'hFE0;
  localparam logic [BUS_AW-1:0] OFS_CLR   = 12'hFE8;
  localparam int DONE_BIT = 2;
endpackage

// File: rtl/nvm_tick_div.sv
module nvm_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (restart || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !restart) |=> !tick);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int TICKS = 4500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    finish = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && tick) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        finish = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/nvm_wake.sv
module nvm_wake #(
  parameter int TICKS = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic tick,
  output logic ready
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          rdy_q, rdy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rdy_d = rdy_q;
    cnt_d = cnt_q;
    if (sleep) begin
      rdy_d = 1'b0;
      cnt_d = '0;
    end else if (!rdy_q && tick) begin
      if (cnt_q == LAST) rdy_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      cnt_q <= cnt_d;
    end
  end

  assign ready = rdy_q;

  // R9
  sleep_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rdy_q);
endmodule

// File: rtl/nvm_cell_ram.sv
module nvm_cell_ram #(
  parameter int WORDS = 128,
  parameter int LOCK_FROM = 96
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata
);
  localparam int IW = $clog2(WORDS);
  localparam logic [IW-1:0] LOCK_IDX = IW'(LOCK_FROM);

  logic [31:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

  // R8
  locked_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> idx < LOCK_IDX);
endmodule

// File: rtl/nvm_word_prog.sv
module nvm_word_prog
  import nvm_prog_pkg::*;
#(
  parameter int ARRAY_BYTES = 512,
  parameter int PAGE_BYTES  = 128,
  parameter int DIV_W       = 8,
  parameter int PROG_TICKS  = 4500,
  parameter int WAKE_TICKS  = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_win,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata
);
  localparam int WORDS   = ARRAY_BYTES / 4;
  localparam int IW      = $clog2(WORDS);
  localparam int LOCK_AT = (ARRAY_BYTES - PAGE_BYTES) / 4;
  localparam logic [IW-1:0] LOCK_IDX = IW'(LOCK_AT);

  logic             mode_q, mode_d;
  logic             sleep_q, sleep_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [BUS_DW-1:0] rdata_q, rdata_d;

  logic reg_wr, reg_rd, mem_wr, mem_rd;
  logic tick, busy, finish, ready, awake, accept, div_wr, clr_hit;
  logic [IW-1:0] idx;
  logic [31:0]   cell_rdata;

  assign reg_wr  = bus_valid &  bus_write & ~bus_win;
  assign reg_rd  = bus_valid & ~bus_write & ~bus_win;
  assign mem_wr  = bus_valid &  bus_write &  bus_win;
  assign mem_rd  = bus_valid & ~bus_write &  bus_win;
  assign idx     = bus_addr[IW+1:2];
  assign awake   = ready & ~sleep_q;
  assign accept  = mem_wr & mode_q & awake & ~busy & (idx < LOCK_IDX);
  assign div_wr  = reg_wr & (bus_addr == OFS_DIV);
  assign clr_hit = reg_wr & (bus_addr == OFS_CLR) & bus_wdata[DONE_BIT];

  nvm_tick_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .div(div_q), .restart(div_wr), .tick(tick));

  nvm_prog_timer #(.TICKS(PROG_TICKS)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .tick(tick),
    .busy(busy), .finish(finish));

  nvm_wake #(.TICKS(WAKE_TICKS)) i_wake (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_q), .tick(tick), .ready(ready));

  nvm_cell_ram #(.WORDS(WORDS), .LOCK_FROM(LOCK_AT)) i_ram (
    .clk(clk), .rst_n(rst_n), .we(accept), .idx(idx),
    .wdata(bus_wdata), .rdata(cell_rdata));

  always_comb begin
    mode_d  = mode_q;
    sleep_d = sleep_q;
    div_d   = div_q;
    if (reg_wr) begin
      if (bus_addr == OFS_MODE)  mode_d  = bus_wdata[0];
      if (bus_addr == OFS_SLEEP) sleep_d = bus_wdata[0];
      if (div_wr)                div_d   = bus_wdata[DIV_W-1:0];
    end
    done_d = done_q;
    if (clr_hit) done_d = 1'b0;
    if (finish)  done_d = 1'b1;
    rdata_d = rdata_q;
    if (reg_rd) begin
      case (bus_addr)
        OFS_MODE:  rdata_d = BUS_DW'(mode_q);
        OFS_DIV:   rdata_d = BUS_DW'(div_q);
        OFS_SLEEP: rdata_d = BUS_DW'(sleep_q);
        OFS_STAT:  rdata_d = BUS_DW'(done_q) << DONE_BIT;
        default:   rdata_d = '0;
      endcase
    end else if (mem_rd) begin
      rdata_d = awake ? cell_rdata : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      sleep_q <= 1'b1;
      done_q  <= 1'b0;
      div_q   <= '0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      sleep_q <= sleep_d;
      done_q  <= done_d;
      div_q   <= div_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy));

  // R9
  asleep_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !awake) |=> bus_rdata == '0);
endmodule

// File: tb/test_nvm_word_prog.sv
module test_nvm_word_prog;
  localparam int PT = 5;
  localparam int WT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_win = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_mode, m_div, m_sleep, m_done, m_busy, m_pcnt, m_ready, m_wcnt, m_dcnt;
  logic [31:0] m_rdata;
  logic [31:0] m_mem [int];

  always #4 clk = ~clk;

  nvm_word_prog #(.PROG_TICKS(PT), .WAKE_TICKS(WT)) i_nvm_word_prog (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_div = 0; m_sleep = 1; m_done = 0; m_busy = 0;
    m_pcnt = 0; m_ready = 0; m_wcnt = 0; m_dcnt = 0; m_rdata = '0;
  endtask

  task automatic model_step(input logic v, input logic w, input logic win,
                            input logic [11:0] a, input logic [31:0] d);
    bit tk, awake, acc, fin;
    int idx;
    tk = (m_dcnt == m_div);
    awake = (m_ready == 1) && (m_sleep == 0);
    idx = int'(a[8:2]);
    acc = v && w && win && m_mode == 1 && awake && m_busy == 0 && idx < 96;
    fin = 0;
    if (v && !w) begin
      if (!win) begin
        case (a)
          12'h00C: m_rdata = m_mode;
          12'h014: m_rdata = m_div;
          12'h018: m_rdata = m_sleep;
          12'hFE0: m_rdata = m_done * 4;
          default: m_rdata = 0;
        endcase
      end else begin
        m_rdata = awake ? (m_mem.exists(idx) ? m_mem[idx] : 32'hx) : 0;
      end
    end
    if (m_sleep == 1) begin
      m_ready = 0; m_wcnt = 0;
    end else if (m_ready == 0 && tk) begin
      if (m_wcnt == WT - 1) m_ready = 1; else m_wcnt++;
    end
    if (acc) begin
      m_busy = 1; m_pcnt = 0; m_mem[idx] = d;
    end else if (m_busy == 1 && tk) begin
      if (m_pcnt == PT - 1) begin m_busy = 0; fin = 1; end
      else m_pcnt++;
    end
    if (v && w && !win && a == 12'hFE8 && d[2]) m_done = 0;
    if (fin) m_done = 1;
    if (v && w && !win && a == 12'h014) m_dcnt = 0;
    else if (tk) m_dcnt = 0;
    else m_dcnt++;
    if (v && w && !win) begin
      if (a == 12'h00C) m_mode = d[0];
      if (a == 12'h018) m_sleep = d[0];
      if (a == 12'h014) m_div = d[7:0];
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic win,
                     input logic [11:0] a, input logic [31:0] d);
    bus_valid = v; bus_write = w; bus_win = win; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(v, w, win, a, d);
    @(negedge clk);
    check({cur_req, " model"}, bus_rdata, m_rdata);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 12'h000, 32'h0);
  endtask

  task automatic rd_chk(input string req, input logic win, input logic [11:0] a,
                        input logic [31:0] exp);
    cur_req = req;
    cyc(1, 0, win, a, 32'h0);
    check(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
    cyc(1, 1, win, a, d);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    check("R1", bus_rdata, 32'h0);
    rd_chk("R1", 0, 12'h018, 32'h1);
    rd_chk("R1", 0, 12'h014, 32'h0);
    rd_chk("R1", 0, 12'h00C, 32'h0);
    rd_chk("R1", 0, 12'hFE0, 32'h0);
    rd_chk("R2", 0, 12'h100, 32'h0);
    rd_chk("R2", 0, 12'hFE8, 32'h0);

    // asleep: reads zero, writes dropped
    rd_chk("R9", 1, 12'h000, 32'h0);
    cur_req = "R9";
    wr(0, 12'h00C, 32'h1);
    rd_chk("R2", 0, 12'h00C, 32'h1);
    cur_req = "R9";
    wr(1, 12'h000, 32'h11);
    idle(10);
    rd_chk("R9", 0, 12'hFE0, 32'h0);

    // wake with div 0: ready after WT ticks
    cur_req = "R9";
    wr(0, 12'h018, 32'h0);
    rd_chk("R9", 1, 12'h000, 32'h0);
    cur_req = "R9";
    wr(1, 12'h000, 32'h22);
    idle(10);
    rd_chk("R9", 0, 12'hFE0, 32'h0);

    // program word 0, collide at E2
    cur_req = "R3";
    wr(1, 12'h000, 32'hA5A5_0001);
    idle(1);
    cur_req = "R7";
    wr(1, 12'h000, 32'hDEAD_BEEF);
    idle(2);
    rd_chk("R5", 0, 12'hFE0, 32'h0);
    rd_chk("R5", 0, 12'hFE0, 32'h4);
    rd_chk("R7", 1, 12'h000, 32'hA5A5_0001);
    rd_chk("R3", 1, 12'h003, 32'hA5A5_0001);
    check("R2", bus_rdata, 32'hA5A5_0001);

    // clear behaviour
    cur_req = "R6";
    wr(0, 12'hFE8, 32'h0);
    rd_chk("R6", 0, 12'hFE0, 32'h4);
    cur_req = "R6";
    wr(0, 12'hFE8, 32'h4);
    rd_chk("R6", 0, 12'hFE0, 32'h0);

    // set wins over clear at the same edge
    cur_req = "R6";
    wr(1, 12'h008, 32'h0000_0C0C);
    idle(4);
    wr(0, 12'hFE8, 32'h4);
    rd_chk("R6", 0, 12'hFE0, 32'h4);
    cur_req = "R6";
    wr(0, 12'hFE8, 32'h4);

    // top page locked, last writable word accepted
    cur_req = "R8";
    wr(1, 12'h180, 32'h7777_7777);
    idle(10);
    rd_chk("R8", 0, 12'hFE0, 32'h0);
    cur_req = "R8";
    wr(1, 12'h1FC, 32'h7777_7777);
    idle(10);
    rd_chk("R8", 0, 12'hFE0, 32'h0);
    cur_req = "R8";
    wr(1, 12'h17C, 32'h0BAD_F00D);
    idle(10);
    rd_chk("R8", 0, 12'hFE0, 32'h4);
    rd_chk("R8", 1, 12'h17C, 32'h0BAD_F00D);
    cur_req = "R8";
    wr(0, 12'hFE8, 32'h4);

    // word mode off
    cur_req = "R10";
    wr(0, 12'h00C, 32'h0);
    wr(1, 12'h000, 32'h5555_5555);
    idle(10);
    rd_chk("R10", 0, 12'hFE0, 32'h0);
    rd_chk("R10", 1, 12'h000, 32'hA5A5_0001);
    cur_req = "R10";
    wr(0, 12'h00C, 32'h1);

    // divider = 2: ticks every 3 clocks
    cur_req = "R4";
    wr(0, 12'h014, 32'h2);
    idle(1);
    wr(1, 12'h004, 32'h0000_1234);
    idle(12);
    rd_chk("R4", 0, 12'hFE0, 32'h0);
    rd_chk("R4", 0, 12'hFE0, 32'h4);
    rd_chk("R2", 0, 12'h014, 32'h2);
    rd_chk("R3", 1, 12'h004, 32'h0000_1234);
    cur_req = "R6";
    wr(0, 12'hFE8, 32'h4);

    // back to sleep
    cur_req = "R9";
    wr(0, 12'h018, 32'h1);
    rd_chk("R9", 1, 12'h004, 32'h0);
    rd_chk("R9", 0, 12'h018, 32'h1);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule